// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the timing core that governs when a delta-sigma converter reports results. It runs on the modulator clock. A register frame ends with the chip-select line going high. The frame's command flags are held steady across that edge, and the block picks them up once the edge has passed through a synchronizer into the modulator clock domain. A start command resets the sequence. The block waits an optional programmed delay, then waits out the filter settling time, which depends on the oversampling ratio and the speed mode. Only then does it announce the first result, with a falling data-ready line and a sticky status flag.

After the first result, a new result is announced every OSR modulator clocks for as long as conversions run. The results themselves stand for the filter output and are modelled only as a running conversion count. A stop command returns the block to idle at once. A new start while conversions run throws away the progress so far and begins again from the top.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, `drdy_n` is 1, `drdy_flag` is 0, `conv_count` is 0, and no result is announced until a start command is taken.
- R2: A start is taken when chip-select rises while `frm_start` is 1 and `frm_stop` is 0. Frames without either flag do not start conversions. The first fall of `drdy_n` comes L modulator clocks after the chip-select rising edge, within plus or minus one clock. Here L = base + speed adder + delay. The base depends on `osr_sel`: code 0 (OSR 16) gives 80, code 1 (32) gives 144, code 2 (128) gives 240, code 3 (256) gives 368, code 4 (512) gives 624, and codes 5 to 7 (1024) give 1136.
- R3: The speed adder depends on `speed_sel`: code 0 adds 0 clocks, codes 1 and 2 add 8, and code 3 adds 24.
- R4: Delay code n on `delay_code` adds n×64 clocks, and code 0 adds none. The delay applies only to the first result after a start.
- R5: After the first result, each further fall of `drdy_n` comes exactly OSR clocks after the previous one.
- R6: On each result, `drdy_n` stays low for exactly OSR−4 clocks and then returns high.
- R7: `drdy_flag` is set by each result. It is cleared when chip-select rises on a frame with `frm_status_rd` set. If a result arrives in the same cycle as the clear, the set wins.
- R8: A start taken while conversions run restarts the whole sequence, delay included. It forces `drdy_n` high and clears `conv_count` to 0.
- R9: A stop is taken when chip-select rises while `frm_stop` is 1, and it takes priority over a start in the same frame. It returns the block to idle: `drdy_n` goes high, no further results are announced, and `conv_count` holds its value.
- R10: OSR, speed mode and delay are captured when the start is taken. Changing them during a run has no effect until the next start.
- R11: `conv_count` increases by one on each result, wrapping at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mod | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select from the serial clock domain; its rising edge ends a frame |
| frm_start | input | 1 | Frame carries a start command (stable across the chip-select rise) |
| frm_stop | input | 1 | Frame carries a stop command |
| frm_status_rd | input | 1 | Frame reads the status register |
| osr_sel | input | 3 | Oversampling ratio code (0:16, 1:32, 2:128, 3:256, 4:512, 5-7:1024) |
| speed_sel | input | 2 | Speed mode code 0 to 3 |
| delay_code | input | 4 | First-conversion delay code, n×64 clocks |
| drdy_n | output | 1 | Data-ready, active low, falls on each settled result |
| drdy_flag | output | 1 | Sticky data-ready status bit |
| conv_count | output | 16 | Number of results since the last start |

## Verification
The bench builds the block with its default parameters: a two-stage chip-select synchronizer, a 12-bit timing counter, a delay step of 64 clocks and a 16-bit conversion count. The 12-bit counter covers the longest first latency of 2120 clocks. With these values the bench can sweep all six OSR codes across all four speed modes, using random delay codes plus codes 0 and 15. It measures every first latency, period and low width in clocks against values computed from the requirement tables. Directed runs cover a status read between results, a configuration change in mid-run, a restart during a run, and a stop followed by a quiet idle interval.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_RUN   = 2'd2
   } seq_state_t;

   // oversampling ratio for a selection code
   function automatic int unsigned osr_of(input logic [2:0] sel);
      case (sel)
         3'd0:    return 16;
         3'd1:    return 32;
         3'd2:    return 128;
         3'd3:    return 256;
         3'd4:    return 512;
         default: return 1024;
      endcase
   endfunction

   // settling latency in speed mode 0
   function automatic int unsigned base_latency(input logic [2:0] sel);
      return osr_of(sel) + ((sel == 3'd0) ? 64 : 112);
   endfunction

   // extra settling caused by the speed mode
   function automatic int unsigned speed_extra(input logic [1:0] spd);
      case (spd)
         2'd0:    return 0;
         2'd3:    return 24;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/adc_cs_sync.sv
module adc_cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_async,
   output logic cs_rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adc_cs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= cs_n_async;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain[STAGES-1];
   end

   assign cs_rise = chain[STAGES-1] & ~last_q;

   assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !cs_rise);

endmodule

// File: rtl/adc_lat_calc.sv
module adc_lat_calc
   import adc_seq_pkg::*;
#(
   parameter int CNT_W    = 12,
   parameter int DLY_STEP = 64
) (
   input  logic [2:0]       osr_sel,
   input  logic [1:0]       speed_sel,
   input  logic [3:0]       delay_code,
   output logic [CNT_W-1:0] first_lat,
   output logic [CNT_W-1:0] period
);
   localparam int MAX_LAT = 15 * DLY_STEP + 1024 + 112 + 24;

   generate
      if (MAX_LAT >= (1 << CNT_W)) begin : g_bad_width
         $error("adc_lat_calc: CNT_W too small for the longest latency");
      end
   endgenerate

   int unsigned lat_sum;

   always_comb begin
      lat_sum   = base_latency(osr_sel) + speed_extra(speed_sel)
                + int'(delay_code) * DLY_STEP;
      first_lat = CNT_W'(lat_sum);
      period    = CNT_W'(osr_of(osr_sel));
   end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int CONV_W    = 16,
   parameter int LOAD_ADJ  = 3,
   parameter int DRDY_GAP  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_start,
   input  logic              take_stop,
   input  logic [CNT_W-1:0]  first_lat,
   input  logic [CNT_W-1:0]  period,
   output logic              drdy_n,
   output logic              result,
   output logic [CONV_W-1:0] conv_count
);
   localparam int MIN_OSR = 16;

   generate
      if (DRDY_GAP + 2 > MIN_OSR) begin : g_bad_gap
         $error("adc_conv_ctrl: DRDY_GAP leaves no low time");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ADJ_V  = CNT_W'(LOAD_ADJ);
   localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(DRDY_GAP);

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] period_q;

   assign result = (state != ST_IDLE) && (cnt == '0) && !take_stop && !take_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         period_q   <= CNT_W'(MIN_OSR);
         drdy_n     <= 1'b1;
         conv_count <= '0;
      end else if (take_stop) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         drdy_n <= 1'b1;
      end else if (take_start) begin
         state      <= ST_FIRST;
         cnt        <= first_lat - ADJ_V;
         period_q   <= period;
         drdy_n     <= 1'b1;
         conv_count <= '0;
      end else if (result) begin
         state      <= ST_RUN;
         cnt        <= period_q - 1'b1;
         drdy_n     <= 1'b0;
         conv_count <= conv_count + 1'b1;
      end else if (state != ST_IDLE) begin
         cnt <= cnt - 1'b1;
         if (state == ST_RUN && cnt == HIGH_V) drdy_n <= 1'b1;
      end
   end

   assert_fall_counts_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_n) |-> conv_count == CONV_W'($past(conv_count) + 1'b1));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> drdy_n);

   assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take_stop |=> (state == ST_IDLE));

   assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (cnt < period_q));

   assert_start_hides_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_start && !take_stop) |=> (drdy_n && conv_count == '0));

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 12,
   parameter int CONV_W      = 16,
   parameter int DLY_STEP    = 64,
   parameter int DRDY_GAP    = 4
) (
   input  logic              clk_mod,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              frm_start,
   input  logic              frm_stop,
   input  logic              frm_status_rd,
   input  logic [2:0]        osr_sel,
   input  logic [1:0]        speed_sel,
   input  logic [3:0]        delay_code,
   output logic              drdy_n,
   output logic              drdy_flag,
   output logic [CONV_W-1:0] conv_count
);
   localparam int LOAD_ADJ = SYNC_STAGES + 1;

   logic             cs_rise;
   logic             take_start;
   logic             take_stop;
   logic             take_rd;
   logic             result;
   logic [CNT_W-1:0] first_lat;
   logic [CNT_W-1:0] period;

   adc_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk_mod),
      .rst_n      (rst_n),
      .cs_n_async (cs_n),
      .cs_rise    (cs_rise)
   );

   assign take_stop  = cs_rise & frm_stop;
   assign take_start = cs_rise & frm_start & ~frm_stop;
   assign take_rd    = cs_rise & frm_status_rd;

   adc_lat_calc #(.CNT_W(CNT_W), .DLY_STEP(DLY_STEP)) u_lat (
      .osr_sel    (osr_sel),
      .speed_sel  (speed_sel),
      .delay_code (delay_code),
      .first_lat  (first_lat),
      .period     (period)
   );

   adc_conv_ctrl #(
      .CNT_W    (CNT_W),
      .CONV_W   (CONV_W),
      .LOAD_ADJ (LOAD_ADJ),
      .DRDY_GAP (DRDY_GAP)
   ) u_ctrl (
      .clk        (clk_mod),
      .rst_n      (rst_n),
      .take_start (take_start),
      .take_stop  (take_stop),
      .first_lat  (first_lat),
      .period     (period),
      .drdy_n     (drdy_n),
      .result     (result),
      .conv_count (conv_count)
   );

   always_ff @(posedge clk_mod or negedge rst_n) begin
      if (!rst_n)       drdy_flag <= 1'b0;
      else if (result)  drdy_flag <= 1'b1;
      else if (take_rd) drdy_flag <= 1'b0;
   end

   assert_flag_on_result_R7: assert property (@(posedge clk_mod) disable iff (!rst_n)
      $rose(drdy_flag) |-> !drdy_n);

endmodule

// File: tb/adc_start_seq_bench.sv
`timescale 1ns/1ps
module adc_start_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        frm_start = 1'b0, frm_stop = 1'b0, frm_status_rd = 1'b0;
   logic [2:0]  osr_sel = 3'd0;
   logic [1:0]  speed_sel = 2'd0;
   logic [3:0]  delay_code = 4'd0;
   logic        drdy_n, drdy_flag;
   logic [15:0] conv_count;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int t_cs = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_start_seq u_adc_start_seq (
      .clk_mod(clk), .rst_n(rst_n), .cs_n(cs_n),
      .frm_start(frm_start), .frm_stop(frm_stop), .frm_status_rd(frm_status_rd),
      .osr_sel(osr_sel), .speed_sel(speed_sel), .delay_code(delay_code),
      .drdy_n(drdy_n), .drdy_flag(drdy_flag), .conv_count(conv_count)
   );

   function automatic int osr_val(input int o);
      case (o)
         0: return 16;  1: return 32;  2: return 128;
         3: return 256; 4: return 512; default: return 1024;
      endcase
   endfunction

   function automatic int exp_first(input int o, input int s, input int d);
      int base, add;
      case (o)
         0: base = 80;  1: base = 144; 2: base = 240;
         3: base = 368; 4: base = 624; default: base = 1136;
      endcase
      add = (s == 0) ? 0 : (s == 3) ? 24 : 8;
      return base + add + d * 64;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic frame(input bit st, input bit sp, input bit rd);
      @(negedge clk);
      frm_start = st; frm_stop = sp; frm_status_rd = rd;
      cs_n = 1'b0;
      repeat (3) @(negedge clk);
      cs_n = 1'b1;
      t_cs = cyc + 1;
      repeat (4) @(negedge clk);
      frm_start = 1'b0; frm_stop = 1'b0; frm_status_rd = 1'b0;
   endtask

   task automatic wait_fall(input int limit, output int t, output bit ok);
      bit prev;
      prev = drdy_n;
      ok = 1'b0;
      t = 0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (prev && !drdy_n) begin
            ok = 1'b1; t = cyc; break;
         end
         prev = drdy_n;
      end
   endtask

   task automatic wait_high(input int limit, output int t);
      t = -1;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (drdy_n) begin t = cyc; break; end
      end
   endtask

   task automatic run_case(input int o, input int s, input int d);
      int l, t1, t2, th, osr;
      bit ok;
      int meas;
      osr = osr_val(o);
      l = exp_first(o, s, d);
      osr_sel = 3'(o); speed_sel = 2'(s); delay_code = 4'(d);
      frame(1'b1, 1'b0, 1'b0);
      wait_fall(l + 50, t1, ok);
      meas = ok ? t1 - t_cs : -1;
      // R2 R3 R4: first latency within one clock
      chk(ok && meas >= l - 1 && meas <= l + 1, "R2/R3/R4 first latency", meas, l);
      chk(drdy_flag == 1'b1, "R7 flag set", int'(drdy_flag), 1);
      chk(conv_count == 16'd1, "R11 count", int'(conv_count), 1);
      wait_high(osr, th);
      chk(th - t1 == osr - 4, "R6 low width", th - t1, osr - 4);
      wait_fall(osr + 10, t2, ok);
      chk(ok && t2 - t1 == osr, "R5/R4 period", t2 - t1, osr);
      chk(conv_count == 16'd2, "R11 count", int'(conv_count), 2);
      frame(1'b0, 1'b1, 1'b0);
      chk(drdy_n == 1'b1, "R9 stop high", int'(drdy_n), 1);
   endtask

   initial begin : watchdog
      wait (cyc > 190000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int t1, t2, th, cnt_hold, seed;
      bit ok;
      seed = 7;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(drdy_n == 1'b1, "R1 drdy_n", int'(drdy_n), 1);
      chk(drdy_flag == 1'b0, "R1 flag", int'(drdy_flag), 0);
      chk(conv_count == 16'd0, "R1 count", int'(conv_count), 0);
      // R2 frame without start does nothing
      frame(1'b0, 1'b0, 1'b1);
      wait_fall(300, t1, ok);
      chk(!ok, "R2 no start no result", int'(ok), 0);

      // sweep of all OSR and speed modes
      for (int o = 0; o < 6; o++) begin
         for (int s = 0; s < 4; s++) begin
            int d;
            if (o == 0 && s == 0)      d = 0;
            else if (o == 1 && s == 3) d = 15;
            else                       d = int'($urandom_range(0, 15));
            run_case(o, s, d);
         end
      end

      // R7 status read clears, next result sets again; R10 config change ignored
      osr_sel = 3'd0; speed_sel = 2'd0; delay_code = 4'd0;
      frame(1'b1, 1'b0, 1'b0);
      wait_fall(200, t1, ok);
      osr_sel = 3'd5; speed_sel = 2'd3; delay_code = 4'd9;
      frame(1'b0, 1'b0, 1'b1);
      chk(drdy_flag == 1'b0, "R7 read clears", int'(drdy_flag), 0);
      wait_fall(100, t2, ok);
      chk(drdy_flag == 1'b1, "R7 set again", int'(drdy_flag), 1);
      chk(ok && t2 - t1 == 16, "R10 period kept", t2 - t1, 16);
      wait_fall(100, t1, ok);
      chk(ok && t1 - t2 == 16, "R10 period kept", t1 - t2, 16);

      // R8 restart during run with the new settings
      osr_sel = 3'd2; speed_sel = 2'd1; delay_code = 4'd2;
      frame(1'b1, 1'b0, 1'b0);
      chk(drdy_n == 1'b1 && conv_count == 16'd0, "R8 restart clears",
          int'(conv_count), 0);
      wait_fall(exp_first(2, 1, 2) + 50, t1, ok);
      chk(ok && (t1 - t_cs) >= exp_first(2, 1, 2) - 1 && (t1 - t_cs) <= exp_first(2, 1, 2) + 1,
          "R8 full latency", t1 - t_cs, exp_first(2, 1, 2));
      chk(conv_count == 16'd1, "R8 count after restart", int'(conv_count), 1);

      // R8 restart in the middle of the first latency
      frame(1'b1, 1'b0, 1'b0);
      repeat (100) @(negedge clk);
      frame(1'b1, 1'b0, 1'b0);
      wait_fall(exp_first(2, 1, 2) + 50, t1, ok);
      chk(ok && (t1 - t_cs) >= exp_first(2, 1, 2) - 1 && (t1 - t_cs) <= exp_first(2, 1, 2) + 1,
          "R8 mid-latency restart", t1 - t_cs, exp_first(2, 1, 2));
      wait_high(200, th);
      wait_fall(200, t2, ok);
      chk(ok && t2 - t1 == 128, "R4 no delay after first", t2 - t1, 128);

      // R9 stop and start in the same frame: stop wins
      frame(1'b1, 1'b1, 1'b0);
      cnt_hold = int'(conv_count);
      wait_fall(1500, t1, ok);
      chk(!ok, "R9 stop quiet", int'(ok), 0);
      chk(int'(conv_count) == cnt_hold, "R9 count holds", int'(conv_count), cnt_hold);
      chk(drdy_n == 1'b1, "R9 idle high", int'(drdy_n), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule